// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block turns interrupt events raised inside the chip into 128-bit records. It stores the records one after another in a circular buffer in system memory, where host software reads and processes them. An event carries an 8-bit source number, 28 bits of source payload, a ring identifier, a virtual-memory context id and a process address-space id. The block packs these fields into a fixed layout and issues one memory write per record, at the ring base plus the current write offset.

The host controls the block through a small register port. The registers hold the global and ring enables, the ring size, the base address, both ring offsets and a writeback address. The block compares the write offset with the host's read offset. It holds its interrupt line up while unread records remain. It reports an overrun with a sticky flag carried in the write-offset word. When writeback is enabled, it also copies the write-offset word to a host-visible memory location after every record. A rearm option drops the interrupt line for one cycle after the host moves its read offset while records are still pending. This gives edge-triggered message delivery a fresh edge.

Top module: `ivr_producer`

## Requirements
- R1: A record written to memory (`mem_kind`=0) places the source number in bits [7:0], the payload in [59:32], the ring id in [71:64], the context id in [79:72] and the address-space id in [95:80]. Every other bit is zero.
- R2: A record goes to byte address BASE*256 + write offset. Each granted record write advances the write offset by 16 modulo the ring length in bytes. The ring length is 4 * 2^S bytes. S is the ring-control field at bits [5:1], limited to the range 2..MAX_LOG2_WORDS. The offset changes in no other way except by a host write to it.
- R3: With overflow detection on (ring-control bit 6), a record write whose advanced offset equals the read offset sets the sticky overflow flag. The flag is bit 0 of the write-offset word. The record is still written and the offset still advances.
- R4: The overflow flag stays set until the host writes ring-control with bit 7 set. That write clears it. Bit 7 is not stored and reads as 0.
- R5: `irq` is high exactly when control bit 0 is set and either the two offsets differ or the overflow flag is set. Rearm (R9) is the only exception.
- R6: `evt_ready` is low while control bit 0 (global enable) or ring-control bit 0 (ring enable) is clear, or while a write is pending. No event is taken and the write offset does not move.
- R7: A host write to the read-offset (register 3) or write-offset (register 4) register loads that offset masked to the ring length, with bits [3:0] forced to zero. Writing zero to both empties the ring.
- R8: With writeback on (ring-control bit 8), each granted record write is followed by a second request with `mem_kind`=1. Its address is {WB_HI[7:0], WB_LO} (registers 6 and 5) and `mem_wdata[31:0]` carries the updated write-offset word. All other data bits are zero.
- R9: With rearm on (control bit 1), a host read-offset write that leaves the offsets different drives `irq` low for exactly the next cycle. `irq` is high again the cycle after that.
- R10: `busy` is high from the cycle after an event is taken until the last grant of its writes. A request holds its address, data and kind until granted. Control is register 0 and base is register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event taken when high together with evt_valid |
| evt_src_id | input | 8 | Source number |
| evt_src_data | input | 28 | Source payload |
| evt_ring_id | input | 8 | Ring identifier |
| evt_vmid | input | 8 | Virtual-memory context id |
| evt_pasid | input | 16 | Process address-space id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_addr | output | 40 | Byte address of the write |
| mem_wdata | output | 128 | Write data |
| mem_kind | output | 1 | 0 = record, 1 = offset writeback |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | A memory write is pending |

## Verification
A write offset that advanced wrongly shows at once as a wrong address on the next record request. It also shows as a wrong value in the write-offset register, which the bench reads after every record. A wrongly kept or lost overflow flag shows in bit 0 of that word and in `irq` in the same cycle. It also shows in the writeback data one request later. A corrupted held record shows in `mem_wdata` during the request itself. Random grant delays expose any request that changes before it is granted, in the very next cycle.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int ADDR_W    = 40;
    localparam int VEC_W     = 128;
    localparam int VEC_BYTES = 16;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_RING  = 3'd1,
        REG_BASE  = 3'd2,
        REG_RPTR  = 3'd3,
        REG_WPTR  = 3'd4,
        REG_WB_LO = 3'd5,
        REG_WB_HI = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vmid;
        logic [15:0] pasid;
    } iv_event_t;

    typedef struct packed {
        logic              intr_en;
        logic              rearm_en;
        logic              ring_en;
        logic [4:0]        size_log2;
        logic              ovf_en;
        logic              wb_en;
        logic [31:0]       base;
        logic [ADDR_W-1:0] wb_addr;
    } ivr_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_WB   = 2'd2
    } wr_state_e;

    function automatic logic [VEC_W-1:0] pack_vector(iv_event_t e);
        return {32'h0, e.pasid, e.vmid, e.ring_id, 4'h0, e.src_data, 24'h0, e.src_id};
    endfunction

    // byte mask for a ring of 2^sz words, record-aligned
    function automatic logic [31:0] ring_byte_mask(logic [4:0] sz);
        logic [31:0] span;
        span = 32'h1 << ({27'h0, sz} + 32'd2);
        return (span - 32'd1) & 32'hFFFF_FFF0;
    endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [31:0] wptr_word,
    input  logic [31:0] rptr_word,
    output ivr_cfg_t    cfg,
    output logic        rptr_wr,
    output logic        wptr_wr,
    output logic        ovf_clr,
    output logic [31:0] reg_rdata
);

    logic [1:0]  ctrl_q;
    logic [7:0]  ring_q;   // {wb_en, ovf_en, size[4:0], ring_en}
    logic [31:0] base_q;
    logic [31:0] wb_lo_q;
    logic [7:0]  wb_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ring_q  <= '0;
            base_q  <= '0;
            wb_lo_q <= '0;
            wb_hi_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                REG_CTRL:  ctrl_q  <= reg_wdata[1:0];
                REG_RING:  ring_q  <= {reg_wdata[8], reg_wdata[6:0]};
                REG_BASE:  base_q  <= reg_wdata;
                REG_WB_LO: wb_lo_q <= reg_wdata;
                REG_WB_HI: wb_hi_q <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    assign rptr_wr = reg_wr && (reg_addr == REG_RPTR);
    assign wptr_wr = reg_wr && (reg_addr == REG_WPTR);
    assign ovf_clr = reg_wr && (reg_addr == REG_RING) && reg_wdata[7];

    always_comb begin
        cfg.intr_en   = ctrl_q[0];
        cfg.rearm_en  = ctrl_q[1];
        cfg.ring_en   = ring_q[0];
        cfg.size_log2 = ring_q[5:1];
        cfg.ovf_en    = ring_q[6];
        cfg.wb_en     = ring_q[7];
        cfg.base      = base_q;
        cfg.wb_addr   = {wb_hi_q, wb_lo_q};
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL:  reg_rdata = {30'h0, ctrl_q};
            REG_RING:  reg_rdata = {23'h0, ring_q[7], 1'b0, ring_q[6:0]};
            REG_BASE:  reg_rdata = base_q;
            REG_RPTR:  reg_rdata = rptr_word;
            REG_WPTR:  reg_rdata = wptr_word;
            REG_WB_LO: reg_rdata = wb_lo_q;
            REG_WB_HI: reg_rdata = {24'h0, wb_hi_q};
            default:   reg_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2_WORDS = 14,
    localparam int PTR_W = MAX_LOG2_WORDS + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       size_log2,
    input  logic             ovf_en,
    input  logic             intr_en,
    input  logic             rearm_en,
    input  logic             vec_done,
    input  logic             wptr_wr,
    input  logic             rptr_wr,
    input  logic             ovf_clr,
    input  logic [31:0]      wdata,
    output logic [PTR_W-1:0] wptr,
    output logic [31:0]      wptr_word,
    output logic [31:0]      rptr_word,
    output logic             ovf,
    output logic             irq
);

    localparam logic [4:0] SZ_MIN = 5'd2;
    localparam logic [4:0] SZ_MAX = 5'(MAX_LOG2_WORDS);

    logic [4:0]       sz_eff;
    logic [31:0]      mask32;
    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] wptr_next;
    logic             full;
    logic             rearm_gap;

    always_comb begin
        if (size_log2 < SZ_MIN)      sz_eff = SZ_MIN;
        else if (size_log2 > SZ_MAX) sz_eff = SZ_MAX;
        else                         sz_eff = size_log2;
    end

    assign mask32    = ring_byte_mask(sz_eff);
    assign mask      = mask32[PTR_W-1:0];
    assign wptr_next = (wptr + PTR_W'(VEC_BYTES)) & mask;
    assign full      = (wptr_next == rptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            rptr      <= '0;
            ovf       <= 1'b0;
            rearm_gap <= 1'b0;
        end else begin
            if (wptr_wr)       wptr <= wdata[PTR_W-1:0] & mask;
            else if (vec_done) wptr <= wptr_next;
            if (rptr_wr)       rptr <= wdata[PTR_W-1:0] & mask;
            if (vec_done && ovf_en && full) ovf <= 1'b1;
            else if (ovf_clr)               ovf <= 1'b0;
            rearm_gap <= rptr_wr && rearm_en;
        end
    end

    assign wptr_word = 32'(wptr) | {31'h0, ovf};
    assign rptr_word = 32'(rptr);
    assign irq       = intr_en && ((wptr != rptr) || ovf) && !rearm_gap;

endmodule

// File: rtl/ivr_wr_seq.sv
module ivr_wr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  iv_event_t         evt_in,
    input  logic              accept_en,
    input  logic              wb_en,
    input  logic [31:0]       base,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [31:0]       wptr_word,
    input  logic              mem_gnt,
    output logic              evt_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [VEC_W-1:0]  mem_wdata,
    output logic              mem_kind,
    output logic              busy,
    output logic              vec_done
);

    wr_state_e        state_q;
    logic [VEC_W-1:0] vec_q;

    assign evt_ready = (state_q == ST_IDLE) && accept_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (evt_valid && evt_ready) begin
                    vec_q   <= pack_vector(evt_in);
                    state_q <= ST_VEC;
                end
                ST_VEC: if (mem_gnt) state_q <= wb_en ? ST_WB : ST_IDLE;
                ST_WB:  if (mem_gnt) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state_q != ST_IDLE);
        mem_kind = (state_q == ST_WB);
        if (state_q == ST_WB) begin
            mem_addr  = wb_addr;
            mem_wdata = {96'h0, wptr_word};
        end else begin
            mem_addr  = {base, 8'h00} + ADDR_W'(wptr);
            mem_wdata = vec_q;
        end
    end

    assign busy     = mem_req;
    assign vec_done = (state_q == ST_VEC) && mem_gnt;

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2_WORDS = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt_valid,
    output logic         evt_ready,
    input  logic [7:0]   evt_src_id,
    input  logic [27:0]  evt_src_data,
    input  logic [7:0]   evt_ring_id,
    input  logic [7:0]   evt_vmid,
    input  logic [15:0]  evt_pasid,
    input  logic         reg_wr,
    input  logic [2:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         mem_req,
    input  logic         mem_gnt,
    output logic [39:0]  mem_addr,
    output logic [127:0] mem_wdata,
    output logic         mem_kind,
    output logic         irq,
    output logic         busy
);

    localparam int PTR_W = MAX_LOG2_WORDS + 2;

    ivr_cfg_t         cfg;
    iv_event_t        evt_in;
    logic             rptr_wr;
    logic             wptr_wr;
    logic             ovf_clr;
    logic             vec_done;
    logic             ovf;
    logic [PTR_W-1:0] wptr;
    logic [31:0]      wptr_word;
    logic [31:0]      rptr_word;

    always_comb begin
        evt_in.src_id   = evt_src_id;
        evt_in.src_data = evt_src_data;
        evt_in.ring_id  = evt_ring_id;
        evt_in.vmid     = evt_vmid;
        evt_in.pasid    = evt_pasid;
    end

    ivr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wptr_word (wptr_word),
        .rptr_word (rptr_word),
        .cfg       (cfg),
        .rptr_wr   (rptr_wr),
        .wptr_wr   (wptr_wr),
        .ovf_clr   (ovf_clr),
        .reg_rdata (reg_rdata)
    );

    ivr_ptr #(.MAX_LOG2_WORDS(MAX_LOG2_WORDS)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .size_log2 (cfg.size_log2),
        .ovf_en    (cfg.ovf_en),
        .intr_en   (cfg.intr_en),
        .rearm_en  (cfg.rearm_en),
        .vec_done  (vec_done),
        .wptr_wr   (wptr_wr),
        .rptr_wr   (rptr_wr),
        .ovf_clr   (ovf_clr),
        .wdata     (reg_wdata),
        .wptr      (wptr),
        .wptr_word (wptr_word),
        .rptr_word (rptr_word),
        .ovf       (ovf),
        .irq       (irq)
    );

    ivr_wr_seq #(.PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_in    (evt_in),
        .accept_en (cfg.intr_en && cfg.ring_en),
        .wb_en     (cfg.wb_en),
        .base      (cfg.base),
        .wb_addr   (cfg.wb_addr),
        .wptr      (wptr),
        .wptr_word (wptr_word),
        .mem_gnt   (mem_gnt),
        .evt_ready (evt_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_kind  (mem_kind),
        .busy      (busy),
        .vec_done  (vec_done)
    );

endmodule

// File: rtl/ivr_producer_chk.sv
module ivr_producer_chk (
    input logic         clk,
    input logic         rst,
    input logic         evt_ready,
    input logic         intr_en,
    input logic         ring_en,
    input logic         wb_en,
    input logic         mem_req,
    input logic         mem_gnt,
    input logic         mem_kind,
    input logic [39:0]  mem_addr,
    input logic [127:0] mem_wdata,
    input logic         irq,
    input logic [31:0]  wptr_word,
    input logic [31:0]  rptr_word,
    input logic         wptr_wr,
    input logic         ovf_clr
);

    AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !(intr_en && ring_en) |-> !evt_ready); // R6

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_kind) |-> (mem_wdata[31:8] == 24'h0 && mem_wdata[63:60] == 4'h0
                                    && mem_wdata[127:96] == 32'h0)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                   && $stable(mem_kind))); // R10

    AST_WB_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && mem_kind) |=> !mem_req); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wptr_word[0] && !ovf_clr) |=> wptr_word[0]); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wptr_word[31:1] == rptr_word[31:1] && !wptr_word[0]) |-> !irq); // R5

    AST_WPTR_STILL: assert property (@(posedge clk) disable iff (rst)
        (!(mem_req && mem_gnt && !mem_kind) && !wptr_wr) |=> $stable(wptr_word[31:4])); // R2

    AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && !mem_kind && wb_en) |=> (mem_req && mem_kind)); // R8

endmodule

bind ivr_producer ivr_producer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_ready (evt_ready),
    .intr_en   (cfg.intr_en),
    .ring_en   (cfg.ring_en),
    .wb_en     (cfg.wb_en),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_kind  (mem_kind),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq       (irq),
    .wptr_word (wptr_word),
    .rptr_word (rptr_word),
    .wptr_wr   (wptr_wr),
    .ovf_clr   (ovf_clr)
);

// File: tb/ivr_producer_bench.sv
`timescale 1ns/1ps
module ivr_producer_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evt_valid = 1'b0;
    logic         evt_ready;
    logic [7:0]   evt_src_id = '0;
    logic [27:0]  evt_src_data = '0;
    logic [7:0]   evt_ring_id = '0;
    logic [7:0]   evt_vmid = '0;
    logic [15:0]  evt_pasid = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req;
    logic         mem_gnt = 1'b0;
    logic [39:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_kind;
    logic         irq;
    logic         busy;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    logic [31:0] m_base = 0, m_wptr = 0, m_rptr = 0, m_mask = 32'hF0;
    logic        m_ovf = 0, m_ovf_en = 0, m_wb_en = 0, m_intr = 0;
    logic [39:0] m_wb_addr = 0;

    always #4 clk = ~clk;

    ivr_producer u_ivr_producer (.*);

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int sz);
        int s;
        s = (sz < 2) ? 2 : (sz > 14 ? 14 : sz);
        return ((32'h1 << (s + 2)) - 1) & 32'hFFFF_FFF0;
    endfunction

    function automatic logic [127:0] exp_vec(input logic [7:0] s, input logic [27:0] d,
                                             input logic [7:0] r, input logic [7:0] v,
                                             input logic [15:0] p);
        logic [127:0] x;
        x = '0;
        x[7:0] = s; x[59:32] = d; x[71:64] = r; x[79:72] = v; x[95:80] = p;
        return x;
    endfunction

    function automatic logic exp_irq();
        return m_intr && ((m_wptr != m_rptr) || m_ovf);
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_ring(input logic en, input int sz, input logic oe, input logic clr, input logic wb);
        reg_write(3'd1, {23'h0, wb, clr, oe, 5'(sz), en});
        m_mask = mask_of(sz); m_ovf_en = oe; m_wb_en = wb;
        if (clr) m_ovf = 1'b0;
    endtask

    task automatic set_rptr(input logic [31:0] v);
        reg_write(3'd3, v);
        m_rptr = v & m_mask;
    endtask

    task automatic serve(input string req, input logic kind, input logic [39:0] addr, input logic [127:0] data);
        int guard = 0;
        while (!mem_req && guard < 20) begin @(negedge clk); guard++; end
        repeat ($urandom % 3) @(negedge clk);
        check({req, " kind"}, 128'(mem_kind), 128'(kind));
        check({req, " addr"}, 128'(mem_addr), 128'(addr));
        check({req, " data"}, mem_wdata, data);
        check("R10 busy during request", 128'(busy), 128'(1));
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
    endtask

    task automatic send_event();
        logic [7:0] s, r, v; logic [27:0] d; logic [15:0] p;
        logic [39:0] a; logic full; logic [31:0] rd; int guard = 0;
        s = 8'($urandom); d = 28'($urandom); r = 8'($urandom); v = 8'($urandom); p = 16'($urandom);
        evt_src_id = s; evt_src_data = d; evt_ring_id = r; evt_vmid = v; evt_pasid = p;
        evt_valid = 1'b1;
        while (!evt_ready && guard < 20) begin @(negedge clk); guard++; end
        @(negedge clk);
        evt_valid = 1'b0;
        a = {m_base, 8'h00} + 40'(m_wptr);
        full = (((m_wptr + 16) & m_mask) == m_rptr);
        serve("R1 R2 record", 1'b0, a, exp_vec(s, d, r, v, p));
        if (m_ovf_en && full) m_ovf = 1'b1;
        m_wptr = (m_wptr + 16) & m_mask;
        if (m_wb_en) serve("R8 writeback", 1'b1, m_wb_addr, {96'h0, m_wptr | 32'(m_ovf)});
        reg_read(3'd4, rd);
        check("R2 R3 write offset word", 128'(rd), 128'(m_wptr | 32'(m_ovf)));
        check("R5 irq after record", 128'(irq), 128'(exp_irq()));
        check("R10 busy idle", 128'(busy), 128'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R6 ready after reset", 128'(evt_ready), 128'(0));
        check("R5 irq after reset", 128'(irq), 128'(0));
        check("R10 busy after reset", 128'(busy), 128'(0));
        reg_read(3'd4, rd);
        check("R7 write offset after reset", 128'(rd), 128'(0));

        // R6: disabled -> nothing taken
        evt_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R6 ready with both enables off", 128'(evt_ready), 128'(0));
            check("R6 no request while off", 128'(mem_req), 128'(0));
        end
        reg_write(3'd0, 32'h1); m_intr = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R6 ready with ring off", 128'(evt_ready), 128'(0));
            check("R6 no request ring off", 128'(mem_req), 128'(0));
        end
        evt_valid = 1'b0;
        reg_read(3'd4, rd);
        check("R6 offset unmoved", 128'(rd), 128'(0));

        // configure 16-word ring (4 records)
        reg_write(3'd2, 32'h00AB_CDEF); m_base = 32'h00AB_CDEF;
        set_ring(1'b1, 4, 1'b1, 1'b0, 1'b0);
        check("R5 irq empty ring", 128'(irq), 128'(0));

        // fill until overflow: fourth record meets rptr=0
        for (int i = 0; i < 4; i++) send_event();
        reg_read(3'd4, rd);
        check("R3 overflow flag set", 128'(rd[0]), 128'(1));
        check("R3 offset wrapped", 128'(rd & 32'hFFFF_FFF0), 128'(0));
        check("R5 irq held by flag", 128'(irq), 128'(1));
        send_event();
        reg_read(3'd4, rd);
        check("R4 flag sticky", 128'(rd[0]), 128'(1));

        // R4: clear
        set_ring(1'b1, 4, 1'b1, 1'b1, 1'b0);
        reg_read(3'd4, rd);
        check("R4 flag cleared", 128'(rd[0]), 128'(0));
        reg_read(3'd1, rd);
        check("R4 clear bit reads zero", 128'(rd[7]), 128'(0));

        // R7: pointer loads
        reg_write(3'd4, 32'h0000_0025); m_wptr = 32'h20;
        reg_read(3'd4, rd);
        check("R7 write offset masked", 128'(rd), 128'(32'h20));
        check("R5 irq pointers differ", 128'(irq), 128'(1));
        set_rptr(32'h0000_002F);
        check("R5 irq pointers equal", 128'(irq), 128'(0));
        reg_write(3'd4, 32'h0); m_wptr = 0;
        set_rptr(32'h0);
        reg_read(3'd3, rd);
        check("R7 read offset zeroed", 128'(rd), 128'(0));

        // R8: writeback
        reg_write(3'd5, 32'h5000_0040);
        reg_write(3'd6, 32'h0000_017F);
        m_wb_addr = {8'h7F, 32'h5000_0040};
        set_ring(1'b1, 4, 1'b1, 1'b0, 1'b1);
        send_event();
        send_event();

        // R9: rearm
        reg_write(3'd0, 32'h3);
        set_rptr(32'h10);
        check("R9 irq dropped one cycle", 128'(irq), 128'(0));
        @(negedge clk);
        check("R9 irq raised again", 128'(irq), 128'(1));
        set_rptr(m_wptr);
        @(negedge clk);
        check("R9 irq stays low when empty", 128'(irq), 128'(0));
        reg_write(3'd0, 32'h1);

        // random phase on a 64-word ring
        reg_write(3'd4, 32'h0); m_wptr = 0;
        set_rptr(32'h0);
        for (int i = 0; i < 80; i++) begin
            if (i % 20 == 0) set_ring(1'b1, 6, 1'b1, 1'b1, 1'($urandom));
            send_event();
            case ($urandom % 3)
                0: set_rptr(m_wptr);
                1: set_rptr($urandom & 32'hFF);
                default: ;
            endcase
        end

        // R2 boundary: size below minimum is treated as 4 words
        reg_write(3'd4, 32'h0); m_wptr = 0;
        set_rptr(32'h0);
        set_ring(1'b1, 1, 1'b0, 1'b1, 1'b0);
        send_event();
        send_event();
        reg_read(3'd4, rd);
        check("R2 smallest ring keeps offset 0", 128'(rd), 128'(0));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule